// File: doc/BRIEF.md
# Line-Code Receiver with Zero-Bit Removal

This block sits behind a line sampler that already produces one clean line level per bit time together with a bit-time enable. On every enabled clock it turns that level back into a data bit. Three line mappings are supported. In the plain level mapping the level is the bit. In the change-on-zero mapping an unchanged level means 1 and a toggle means 0. In the change-on-one mapping a toggle means 1 and a steady level means 0. The two transition-based mappings compare each sample against the level of the previous sample. That stored level starts out at the idle value 1.

The decoded stream then passes through a zero-bit remover. The run length is selectable: a short run of five ones or a long run of six ones. A 0 that follows a complete run was inserted by the transmitter and is dropped, so no valid strobe is produced for it. A 1 in that position breaks the stuffing rule and raises a one-cycle error pulse. There is one exception, which applies with the short run. A sixth 1 is still allowed there, because the frame delimiter 01111110 has six ones in a row. If a 0 closes such a run and a 0 came before the run, the flag-detect output pulses. All outputs are registered and appear on the clock after the enabled sample.

Top module: `nrzi_rx`

## Requirements
- R1: While reset is active, and until the first enabled sample after reset, `dout_vld`, `stuff_err` and `flag_det` are 0.
- R2: With `line_mode` = 2'b00 (or 2'b11) the decoded bit equals the sampled `line_in`.
- R3: With `line_mode` = 2'b01 a sample equal to the previous sampled level decodes as 1, and a differing sample decodes as 0.
- R4: With `line_mode` = 2'b10 a sample differing from the previous sampled level decodes as 1, and an equal sample decodes as 0.
- R5: Outputs change only on the clock after a sample taken with `bit_en` = 1. `dout_vld`, `stuff_err` and `flag_det` are single-cycle pulses. `line_in` is ignored while `bit_en` = 0, and the previous-level register keeps its value.
- R6: With `long_run` = 1, a decoded 0 that follows six consecutive decoded 1s is dropped and produces no `dout_vld`.
- R7: With `long_run` = 1, a decoded 1 that follows six consecutive 1s raises `stuff_err` for one cycle, produces no `dout_vld`, and restarts the run count.
- R8: With `long_run` = 0, a decoded 0 that follows five consecutive 1s is dropped and produces no `dout_vld`.
- R9: With `long_run` = 0, a 0 that follows exactly six 1s is delivered as data. If a decoded 0 came before those ones, `flag_det` pulses together with that `dout_vld`, so the pattern 01111110 is flagged and gives no error.
- R10: With `long_run` = 0, a seventh consecutive 1 raises `stuff_err`, produces no `dout_vld`, and restarts the run count.
- R11: The ones counter clears on every decoded 0, including the dropped stuffed zeros.
- R12: The previous-level register resets to 1, so the first sample after reset is decoded against a high idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit-time enable; `line_in` is sampled when high |
| line_in | input | 1 | Sampled line level |
| line_mode | input | 2 | 00 level, 01 change-on-zero, 10 change-on-one, 11 level |
| long_run | input | 1 | 1: six-ones run length, 0: five-ones run length with flag detection |
| dout | output | 1 | Decoded data bit, meaningful when `dout_vld` is high |
| dout_vld | output | 1 | One-cycle strobe for a delivered data bit |
| stuff_err | output | 1 | One-cycle pulse on a stuffing-rule violation |
| flag_det | output | 1 | One-cycle pulse on the closing 0 of a 01111110 delimiter |

## Verification
The bench encodes each bit pattern onto the line with its own model of each mapping, starting from a high idle level. It then compares the delivered bits, their count and the error and flag pulses. Several failure modes are targeted:
- A decoder that compares the first sample against a low level inverts the first bit of every frame after reset.
- A counter that is not cleared by a dropped stuffed zero reports a false error in the second run of ones.
- A destuffer that treats the sixth 1 with the short run as an error never reports a delimiter.
- A destuffer that drops the closing 0 of a delimiter loses one data bit.
- A decoder that updates the stored level on cycles without an enable decodes the next sample wrongly after the line moves between bit times.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;
  typedef enum logic [1:0] {
    LINE_LEVEL = 2'b00,
    LINE_SPACE = 2'b01,
    LINE_MARK  = 2'b10,
    LINE_ALT   = 2'b11
  } line_mode_e;
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/nrzi_line_decode.sv
module nrzi_line_decode
  import nrzi_rx_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_en,
  input  logic       line_in,
  input  line_mode_e mode,
  output logic       bit_out
);
  logic prev_q, prev_d;
  logic toggled;

  assign toggled = line_in ^ prev_q;

  always_comb begin
    unique case (mode)
      LINE_SPACE: bit_out = ~toggled;
      LINE_MARK:  bit_out = toggled;
      default:    bit_out = line_in;
    endcase
  end

  always_comb begin
    prev_d = prev_q;
    if (samp_en) prev_d = line_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LEVEL;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/nrzi_bit_destuff.sv
module nrzi_bit_destuff #(
  parameter int RUN_SHORT = 5,
  parameter int RUN_LONG  = 6,
  localparam int CNT_W    = $clog2(RUN_LONG + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic long_run,
  output logic dout,
  output logic dout_vld,
  output logic stuff_err,
  output logic flag_det
);
  localparam logic [CNT_W-1:0] THR_S = CNT_W'(RUN_SHORT);
  localparam logic [CNT_W-1:0] THR_L = CNT_W'(RUN_LONG);

  logic [CNT_W-1:0] ones_q, ones_d, thr;
  logic             seen0_q, seen0_d;
  logic             dat_q, dat_d, vld_q, vld_d, err_q, err_d, flg_q, flg_d;

  assign thr = long_run ? THR_L : THR_S;

  always_comb begin
    ones_d  = ones_q;
    seen0_d = seen0_q;
    dat_d   = dat_q;
    vld_d   = 1'b0;
    err_d   = 1'b0;
    flg_d   = 1'b0;
    if (bit_en) begin
      if (ones_q == thr && !bit_in) begin
        ones_d  = '0;              // inserted zero: dropped
        seen0_d = 1'b1;
      end else if (ones_q == thr && long_run) begin
        err_d   = 1'b1;
        ones_d  = '0;
        seen0_d = 1'b0;
      end else if (ones_q == thr) begin
        vld_d   = 1'b1;            // sixth one of a possible delimiter
        dat_d   = 1'b1;
        ones_d  = ones_q + 1'b1;
      end else if (ones_q > thr) begin
        if (bit_in) begin
          err_d   = 1'b1;
          ones_d  = '0;
          seen0_d = 1'b0;
        end else begin
          vld_d   = 1'b1;
          dat_d   = 1'b0;
          flg_d   = seen0_q;
          ones_d  = '0;
          seen0_d = 1'b1;
        end
      end else begin
        vld_d  = 1'b1;
        dat_d  = bit_in;
        ones_d = bit_in ? ones_q + 1'b1 : '0;
        if (!bit_in) seen0_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= '0;
      seen0_q <= 1'b0;
      dat_q   <= 1'b0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      flg_q   <= 1'b0;
    end else begin
      ones_q  <= ones_d;
      seen0_q <= seen0_d;
      dat_q   <= dat_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
      flg_q   <= flg_d;
    end
  end

  assign dout      = dat_q;
  assign dout_vld  = vld_q;
  assign stuff_err = err_q;
  assign flag_det  = flg_q;
endmodule

// File: rtl/nrzi_rx.sv
module nrzi_rx
  import nrzi_rx_pkg::*;
#(
  parameter int RUN_SHORT  = 5,
  parameter int RUN_LONG   = 6,
  parameter int SYNC_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       line_in,
  input  logic [1:0] line_mode,
  input  logic       long_run,
  output logic       dout,
  output logic       dout_vld,
  output logic       stuff_err,
  output logic       flag_det
);
  logic srst_n;
  logic dec_bit;

  rx_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  nrzi_line_decode #(.IDLE_LEVEL(1'b1)) u_dec (
    .clk     (clk),
    .rst_n   (srst_n),
    .samp_en (bit_en),
    .line_in (line_in),
    .mode    (line_mode_e'(line_mode)),
    .bit_out (dec_bit)
  );

  nrzi_bit_destuff #(.RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)) u_dst (
    .clk       (clk),
    .rst_n     (srst_n),
    .bit_en    (bit_en),
    .bit_in    (dec_bit),
    .long_run  (long_run),
    .dout      (dout),
    .dout_vld  (dout_vld),
    .stuff_err (stuff_err),
    .flag_det  (flag_det)
  );
endmodule

// File: rtl/nrzi_rx_chk.sv
module nrzi_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic dout,
  input logic dout_vld,
  input logic stuff_err,
  input logic flag_det
);
  // R5
  vld_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> $past(bit_en));
  // R5
  err_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> $past(bit_en));
  // R7
  err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> !dout_vld);
  // R9
  flag_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_det |-> (dout_vld && !dout && !stuff_err));
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_vld && !bit_en) |=> !dout_vld);
endmodule

bind nrzi_rx nrzi_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .dout      (dout),
  .dout_vld  (dout_vld),
  .stuff_err (stuff_err),
  .flag_det  (flag_det)
);

// File: tb/tb_nrzi_rx.sv
module tb_nrzi_rx;
  logic clk = 1'b0;
  logic rst_n, bit_en, line_in, long_run;
  logic [1:0] line_mode;
  logic dout, dout_vld, stuff_err, flag_det;

  int n_chk = 0;
  int n_err = 0;
  logic cur_lvl;

  always #10 clk = ~clk;

  nrzi_rx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_in(line_in),
    .line_mode(line_mode), .long_run(long_run), .dout(dout),
    .dout_vld(dout_vld), .stuff_err(stuff_err), .flag_det(flag_det)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        lng;
    logic [4:0]  n;
    logic [15:0] bits;
    logic [4:0]  en;
    logic [15:0] eb;
    logic        err;
    logic        flg;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 1'b1, 5'd8,  16'h0065, 5'd8,  16'h0065, 1'b0, 1'b0},  // R2
    '{2'd1, 1'b1, 5'd6,  16'h0032, 5'd6,  16'h0032, 1'b0, 1'b0},  // R3
    '{2'd2, 1'b1, 5'd7,  16'h004D, 5'd7,  16'h004D, 1'b0, 1'b0},  // R4
    '{2'd1, 1'b1, 5'd9,  16'h00BF, 5'd8,  16'h007F, 1'b0, 1'b0},  // R6
    '{2'd2, 1'b1, 5'd7,  16'h007F, 5'd6,  16'h003F, 1'b1, 1'b0},  // R7
    '{2'd0, 1'b0, 5'd7,  16'h005F, 5'd6,  16'h003F, 1'b0, 1'b0},  // R8
    '{2'd1, 1'b0, 5'd8,  16'h007E, 5'd8,  16'h007E, 1'b0, 1'b1},  // R9
    '{2'd2, 1'b0, 5'd8,  16'h00FE, 5'd7,  16'h007E, 1'b1, 1'b0},  // R10
    '{2'd1, 1'b1, 5'd14, 16'h1FBF, 5'd12, 16'h0FFF, 1'b0, 1'b0},  // R11
    '{2'd2, 1'b0, 5'd9,  16'h00FD, 5'd9,  16'h00FD, 1'b0, 1'b1}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_en = 1'b0; line_in = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cur_lvl = 1'b1;
  endtask

  // drive one level with enable; on return the registered result is visible
  task automatic send_lvl(input logic lvl);
    @(negedge clk);
    line_in = lvl; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  function automatic logic encode(input logic [1:0] m, input logic b, input logic c);
    if (m == 2'd1) return b ? c : ~c;
    if (m == 2'd2) return b ? ~c : c;
    return b;
  endfunction

  initial begin
    #(20ns * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    line_mode = 2'd0; long_run = 1'b1;
    rst_n = 1'b0; bit_en = 1'b0; line_in = 1'b1;
    repeat (2) @(negedge clk);
    // R1 outputs quiet during reset
    chk("R1 vld", dout_vld, 0);
    chk("R1 err", stuff_err, 0);
    chk("R1 flag", flag_det, 0);

    for (int v = 0; v < 10; v++) begin
      logic [15:0] rx;
      int rc;
      logic e, f;
      line_mode = VECS[v].mode; long_run = VECS[v].lng;
      do_reset();
      rx = '0; rc = 0; e = 1'b0; f = 1'b0;
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        cur_lvl = encode(VECS[v].mode, VECS[v].bits[i], cur_lvl);
        send_lvl(cur_lvl);
        if (dout_vld && rc < 16) begin rx[rc] = dout; rc++; end
        e |= stuff_err; f |= flag_det;
      end
      chk($sformatf("R2/R11 row %0d count", v), rc, VECS[v].en);
      chk($sformatf("R3/R4/R6/R8 row %0d bits", v), rx, VECS[v].eb);
      chk($sformatf("R7/R10 row %0d err", v), e, VECS[v].err);
      chk($sformatf("R9 row %0d flag", v), f, VECS[v].flg);
    end

    // R12 first sample compared against high idle
    line_mode = 2'd2; do_reset();
    send_lvl(1'b1);
    chk("R12 mark steady vld", dout_vld, 1);
    chk("R12 mark steady bit", dout, 0);
    do_reset(); send_lvl(1'b0);
    chk("R12 mark toggle bit", dout, 1);
    line_mode = 2'd1; do_reset(); send_lvl(1'b1);
    chk("R12 space steady bit", dout, 1);

    // R5 pulse lasts one cycle, no strobe without enable
    @(negedge clk);
    chk("R5 vld pulse ends", dout_vld, 0);
    line_mode = 2'd2; do_reset();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); line_in = ~line_in;
      chk("R5 no vld without enable", dout_vld, 0);
    end
    line_in = 1'b0;
    repeat (2) @(negedge clk);
    send_lvl(1'b1);
    chk("R5 ignored level not stored", dout, 0);

    // R1 reset clears a run in progress
    line_mode = 2'd0; long_run = 1'b1; do_reset();
    for (int k = 0; k < 5; k++) send_lvl(1'b1);
    do_reset();
    send_lvl(1'b1); send_lvl(1'b1);
    chk("R1 run cleared by reset", stuff_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule